// File: doc/BRIEF.md
# Rotating-Ring Vector Arithmetic Unit

This block is a small vector execution unit whose vector registers are circular shift rings rather than addressed arrays. Element 0 of a ring always sits at its head. An element is reached by rotating the ring until it arrives at the head, never by indexing. A command names a destination register, two source registers and an operation (add, subtract or multiply on 16-bit integers). The unit then streams the two source heads through a single registered arithmetic stage and shifts each result into the tail of the destination ring.

A source ring rotates once per step for a vector length of steps, so it ends where it began. The destination ring rotates one step later, on the cycles when the pipeline stage holds a valid result. When the destination is also a source, each result lands in the slot its own operand has just left. An in-place operation therefore reads every original operand. A parallel load port fills all elements of one register at once. A combinational read port returns every element of a selected register, which lets software or a bench inspect the state.

The controller is a four-state machine. IDLE moves to RUN when a start with a legal operation code is accepted. RUN stays in RUN while the step counter is below the last element, and moves to FLUSH after the last source step. FLUSH writes the final result and moves to DONE. DONE raises the one-cycle done pulse and returns to IDLE.

Top module: `rvp_top`

## Requirements
- R1: After reset, busy and done are low and every element of every register reads zero.
- R2: With the unit idle, a load writes all elements of the selected register from the load bus in the next cycle. The read port returns element i of the selected register on bits [16*i+15:16*i] combinationally.
- R3: Operation code 0 writes dst[i] = a[i] + b[i] modulo 2^16 for every element i.
- R4: Operation code 1 writes dst[i] = a[i] - b[i] modulo 2^16 for every element i.
- R5: Operation code 2 writes the low 16 bits of a[i] * b[i] to dst[i] for every element i.
- R6: A start with operation code 3 is not accepted. Busy stays low, no done pulse follows, and no register changes.
- R7: After an accepted start, busy is high from the next cycle for exactly vector-length + 2 cycles. Done is high only in the last of those cycles, as a single-cycle pulse.
- R8: While busy is high, both start and load requests are ignored.
- R9: Source registers that are not the destination hold their original contents when the operation ends.
- R10: The result is correct when the destination equals a source, and when both sources name the same register.
- R11: A load and an accepted start in the same idle cycle both take effect. The operation uses the newly loaded contents.
- R12: Registers named neither as destination nor as source are left unchanged by an operation, and nothing changes while idle without a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start request, sampled when idle |
| cmd_op | input | 2 | 0 add, 1 subtract, 2 multiply, 3 reserved |
| cmd_dst | input | 2 | Destination register index |
| cmd_srca | input | 2 | First source register index |
| cmd_srcb | input | 2 | Second source register index |
| cmd_busy | output | 1 | High while an operation is in progress |
| cmd_done | output | 1 | One-cycle pulse after the last result is written |
| ld_en | input | 1 | Parallel load request |
| ld_sel | input | 2 | Register to load |
| ld_data | input | 64 | All elements, element i on bits [16*i+15:16*i] |
| rd_sel | input | 2 | Register to read |
| rd_data | output | 64 | All elements of the selected register |

## Verification
A load request and a command start can arrive in the same cycle. Which wins depends on whether the unit is idle. When idle, both are taken: the load lands at the same edge that latches the command, and the first source step reads the fresh data. When busy, both are dropped. The bench raises load and start together while idle and targets a source register with the load. It judges the outcome by comparing the destination against a model built from the loaded values. It then raises both again in the middle of a running operation and judges that no second operation follows and that the loaded register keeps its old contents.

// File: rtl/rvp_pkg.sv
package rvp_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_RSV = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2,
        ST_DONE  = 2'd3
    } st_e;

endpackage

// File: rtl/rvp_ring.sv
module rvp_ring #(
    parameter int NELEM = 4,
    parameter int W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [NELEM*W-1:0] load_data,
    input  logic               rot,
    input  logic [W-1:0]       tail_in,
    output logic [W-1:0]       head,
    output logic [NELEM*W-1:0] contents
);

    logic [W-1:0] slot_q [NELEM];

    // Slot 0 is the head; rotation moves every slot one place toward it.
    for (genvar e = 0; e < NELEM; e++) begin : g_slot
        logic [W-1:0] shift_src;
        if (e == NELEM - 1) begin : g_tail
            assign shift_src = tail_in;
        end else begin : g_body
            assign shift_src = slot_q[e+1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[e] <= '0;
            end else if (load_en) begin
                slot_q[e] <= load_data[e*W +: W];
            end else if (rot) begin
                slot_q[e] <= shift_src;
            end
        end

        assign contents[e*W +: W] = slot_q[e];
    end

    assign head = slot_q[0];

endmodule

// File: rtl/rvp_alu.sv
module rvp_alu
    import rvp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  op_e          op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] res,
    output logic         res_vld
);

    logic [W-1:0] f;

    always_comb begin
        unique case (op)
            OP_ADD:  f = opa + opb;
            OP_SUB:  f = opa - opb;
            OP_MUL:  f = opa * opb;
            default: f = opa + opb;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res     <= '0;
            res_vld <= 1'b0;
        end else begin
            res_vld <= en;
            if (en) begin
                res <= f;
            end
        end
    end

endmodule

// File: rtl/rvp_ctrl.sv
module rvp_ctrl
    import rvp_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int NELEM = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [1:0]              op_in,
    input  logic [$clog2(NREG)-1:0] dst_in,
    input  logic [$clog2(NREG)-1:0] sa_in,
    input  logic [$clog2(NREG)-1:0] sb_in,
    output logic                    busy,
    output logic                    done,
    output logic                    run,
    output op_e                     op,
    output logic [$clog2(NREG)-1:0] dst,
    output logic [$clog2(NREG)-1:0] sa,
    output logic [$clog2(NREG)-1:0] sb
);

    localparam int RW = $clog2(NREG);
    localparam int CW = (NELEM > 1) ? $clog2(NELEM) : 1;
    localparam logic [CW-1:0] LAST = CW'(NELEM - 1);

    st_e           st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          accept;

    assign accept = (st_q == ST_IDLE) && start && (op_e'(op_in) != OP_RSV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            op    <= OP_ADD;
            dst   <= '0;
            sa    <= '0;
            sb    <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_RUN) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
            if (accept) begin
                op  <= op_e'(op_in);
                dst <= RW'(dst_in);
                sa  <= RW'(sa_in);
                sb  <= RW'(sb_in);
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (accept) st_d = ST_RUN;
            ST_RUN:   if (cnt_q == LAST) st_d = ST_FLUSH;
            ST_FLUSH: st_d = ST_DONE;
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        run  = 1'b0;
        unique case (st_q)
            ST_IDLE:  ;
            ST_RUN:   begin busy = 1'b1; run = 1'b1; end
            ST_FLUSH: busy = 1'b1;
            ST_DONE:  begin busy = 1'b1; done = 1'b1; end
            default:  ;
        endcase
    end

endmodule

// File: rtl/rvp_top.sv
module rvp_top
    import rvp_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int NELEM = 4,
    parameter int W     = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_start,
    input  logic [1:0]              cmd_op,
    input  logic [$clog2(NREG)-1:0] cmd_dst,
    input  logic [$clog2(NREG)-1:0] cmd_srca,
    input  logic [$clog2(NREG)-1:0] cmd_srcb,
    output logic                    cmd_busy,
    output logic                    cmd_done,
    input  logic                    ld_en,
    input  logic [$clog2(NREG)-1:0] ld_sel,
    input  logic [NELEM*W-1:0]      ld_data,
    input  logic [$clog2(NREG)-1:0] rd_sel,
    output logic [NELEM*W-1:0]      rd_data
);

    localparam int RW = $clog2(NREG);
    localparam int VW = NELEM * W;

    logic          busy, done, run, res_vld;
    op_e           op;
    logic [RW-1:0] dst, sa, sb;
    logic [W-1:0]  res;
    logic [W-1:0]  head   [NREG];
    logic [VW-1:0] ring_q [NREG];
    logic [NREG*VW-1:0] all_flat;

    rvp_ctrl #(.NREG(NREG), .NELEM(NELEM)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (cmd_start),
        .op_in  (cmd_op),
        .dst_in (cmd_dst),
        .sa_in  (cmd_srca),
        .sb_in  (cmd_srcb),
        .busy   (busy),
        .done   (done),
        .run    (run),
        .op     (op),
        .dst    (dst),
        .sa     (sa),
        .sb     (sb)
    );

    rvp_alu #(.W(W)) u_alu (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (run),
        .op      (op),
        .opa     (head[sa]),
        .opb     (head[sb]),
        .res     (res),
        .res_vld (res_vld)
    );

    for (genvar r = 0; r < NREG; r++) begin : g_ring
        logic is_src, is_dst, rot, ld_hit;
        logic [W-1:0] tail;

        assign is_src = run && ((sa == RW'(r)) || (sb == RW'(r)));
        assign is_dst = res_vld && (dst == RW'(r));
        assign rot    = is_src || is_dst;
        assign tail   = is_dst ? res : head[r];
        assign ld_hit = ld_en && !busy && (ld_sel == RW'(r));

        rvp_ring #(.NELEM(NELEM), .W(W)) u_ring (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_en   (ld_hit),
            .load_data (ld_data),
            .rot       (rot),
            .tail_in   (tail),
            .head      (head[r]),
            .contents  (ring_q[r])
        );

        assign all_flat[r*VW +: VW] = ring_q[r];
    end

    assign rd_data  = ring_q[rd_sel];
    assign cmd_busy = busy;
    assign cmd_done = done;

endmodule

// File: rtl/rvp_chk.sv
module rvp_chk #(
    parameter int NREG  = 4,
    parameter int NELEM = 4,
    parameter int W     = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic [1:0]              op,
    input logic                    busy,
    input logic                    done,
    input logic                    ld_en,
    input logic [NREG*NELEM*W-1:0] all_flat
);

    localparam int BW = $clog2(NELEM + 4) + 1;

    logic [BW-1:0] bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt <= '0;
        end else if (!busy) begin
            bcnt <= '0;
        end else begin
            bcnt <= bcnt + 1'b1;
        end
    end

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op != 2'd3) |=> busy);

    p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bcnt == BW'(NELEM + 1)));

    p_rsv_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && op == 2'd3) |=> !busy);

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ld_en) |=> $stable(all_flat));

endmodule

bind rvp_top rvp_chk #(.NREG(NREG), .NELEM(NELEM), .W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cmd_start),
    .op       (cmd_op),
    .busy     (cmd_busy),
    .done     (cmd_done),
    .ld_en    (ld_en),
    .all_flat (all_flat)
);

// File: tb/tb_rvp_top.sv
`timescale 1ns/1ps
module tb_rvp_top;

    localparam int NREG = 4, NELEM = 4, W = 16;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cmd_start = 0, ld_en = 0;
    logic [1:0]  cmd_op = 0, cmd_dst = 0, cmd_srca = 0, cmd_srcb = 0, ld_sel = 0, rd_sel = 0;
    logic [63:0] ld_data = 0;
    logic        cmd_busy, cmd_done;
    logic [63:0] rd_data;

    int n_cmp = 0, n_bad = 0;
    logic [15:0] mdl [NREG][NELEM];

    always #4 clk = ~clk;

    rvp_top #(.NREG(NREG), .NELEM(NELEM), .W(W)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_dst(cmd_dst), .cmd_srca(cmd_srca), .cmd_srcb(cmd_srcb),
        .cmd_busy(cmd_busy), .cmd_done(cmd_done), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_data(ld_data), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] f_op(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b);
        case (op)
            2'd0: return a + b;
            2'd1: return a - b;
            default: return 16'(a * b);
        endcase
    endfunction

    task automatic cmp_all(input string req);
        for (int r = 0; r < NREG; r++) begin
            rd_sel = 2'(r);
            #1;
            for (int e = 0; e < NELEM; e++) chk(req, {48'd0, rd_data[e*16 +: 16]}, {48'd0, mdl[r][e]});
        end
    endtask

    task automatic load(input logic [1:0] sel, input logic [63:0] v);
        @(negedge clk);
        ld_en = 1; ld_sel = sel; ld_data = v;
        @(negedge clk);
        ld_en = 0;
        for (int e = 0; e < NELEM; e++) mdl[sel][e] = v[e*16 +: 16];
    endtask

    // One operation with timing checks; optional same-cycle load and mid-run injection.
    task automatic do_op(input logic [1:0] d, a, b, op, input bit same_ld, input logic [1:0] lsel,
                         input logic [63:0] lv, input bit inject, input string req);
        logic [15:0] r [NELEM];
        int cyc, done_at, ndone;
        if (same_ld) for (int e = 0; e < NELEM; e++) mdl[lsel][e] = lv[e*16 +: 16];
        for (int e = 0; e < NELEM; e++) r[e] = f_op(op, mdl[a][e], mdl[b][e]);
        @(negedge clk);
        cmd_start = 1; cmd_op = op; cmd_dst = d; cmd_srca = a; cmd_srcb = b;
        if (same_ld) begin ld_en = 1; ld_sel = lsel; ld_data = lv; end
        @(negedge clk);
        cmd_start = 0; ld_en = 0;
        cyc = 1; done_at = 0; ndone = 0;
        while (cmd_busy && cyc < 50) begin
            if (cmd_done) begin done_at = cyc; ndone++; end
            if (inject && cyc == 2) begin
                cmd_start = 1; cmd_op = 2'd1; cmd_dst = 2'd3; ld_en = 1; ld_sel = 2'd3; ld_data = 64'hDEAD_DEAD_DEAD_DEAD;
            end else begin
                cmd_start = 0; ld_en = 0;
            end
            @(negedge clk);
            cyc++;
        end
        cmd_start = 0; ld_en = 0;
        chk({req, " R7 done cycle"}, 64'(done_at), 64'(NELEM + 2));
        chk({req, " R7 done count"}, 64'(ndone), 64'd1);
        chk({req, " R7 busy length"}, 64'(cyc), 64'(NELEM + 3));
        for (int e = 0; e < NELEM; e++) mdl[d][e] = r[e];
        cmp_all(req);
        @(negedge clk);
        chk({req, " R8 no restart"}, {63'd0, cmd_busy}, 64'd0);
    endtask

    task automatic t_reset();
        chk("R1 busy", {63'd0, cmd_busy}, 64'd0);
        chk("R1 done", {63'd0, cmd_done}, 64'd0);
        cmp_all("R1 zero regs");
    endtask

    task automatic t_load();
        load(2'd0, 64'h0004_0003_0002_0001);
        load(2'd1, 64'h0040_0030_0020_FFFF);
        load(2'd2, 64'h8000_0100_1234_0003);
        load(2'd3, 64'hAAAA_5555_0F0F_F0F0);
        cmp_all("R2 load readback");
    endtask

    task automatic t_add();  do_op(2'd2, 2'd0, 2'd1, 2'd0, 0, 0, 0, 0, "R3 R9 R12 add");  endtask
    task automatic t_sub();  do_op(2'd3, 2'd0, 2'd1, 2'd1, 0, 0, 0, 0, "R4 sub");  endtask
    task automatic t_mul();
        load(2'd2, 64'h8000_0100_1234_0003);
        do_op(2'd1, 2'd2, 2'd0, 2'd2, 0, 0, 0, 0, "R5 mul");
    endtask

    task automatic t_rsv();
        int busy_seen = 0, done_seen = 0;
        @(negedge clk);
        cmd_start = 1; cmd_op = 2'd3; cmd_dst = 2'd0; cmd_srca = 2'd1; cmd_srcb = 2'd2;
        @(negedge clk);
        cmd_start = 0;
        for (int i = 0; i < 8; i++) begin
            if (cmd_busy) busy_seen++;
            if (cmd_done) done_seen++;
            @(negedge clk);
        end
        chk("R6 busy stays low", 64'(busy_seen), 64'd0);
        chk("R6 no done", 64'(done_seen), 64'd0);
        cmp_all("R6 regs unchanged");
    endtask

    task automatic t_busy_block();
        do_op(2'd0, 2'd1, 2'd2, 2'd0, 0, 0, 0, 1, "R8 start and load while busy");
    endtask

    task automatic t_inplace();
        load(2'd1, 64'h0010_FFFE_7FFF_0005);
        do_op(2'd1, 2'd1, 2'd2, 2'd1, 0, 0, 0, 0, "R10 dst is srca");
        do_op(2'd2, 2'd0, 2'd2, 2'd0, 0, 0, 0, 0, "R10 dst is srcb");
        do_op(2'd3, 2'd0, 2'd0, 2'd2, 0, 0, 0, 0, "R10 same sources");
        do_op(2'd0, 2'd0, 2'd0, 2'd0, 0, 0, 0, 0, "R10 all same");
    endtask

    task automatic t_same_cycle();
        do_op(2'd3, 2'd2, 2'd1, 2'd0, 1, 2'd2, 64'h1111_2222_3333_4444, 0, "R11 load with start");
    endtask

    initial begin
        for (int r = 0; r < NREG; r++) for (int e = 0; e < NELEM; e++) mdl[r][e] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_load();
        t_add();
        t_sub();
        t_mul();
        t_rsv();
        t_busy_block();
        t_inplace();
        t_same_cycle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R7 watchdog act=timeout exp=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule